// File: doc/BRIEF.md
# Circular-Region Frame Transmit Engine

This block sends one frame out of the transmit region of a byte-wide packet SRAM each time software starts it. A strobe, standing for a write of 1 into bit 0 of the transmit control register, starts the block. The block then reads the byte count from the 16-bit length register and caps it at 3072. It fetches that many bytes, starting at its transmit read pointer, and presents them one at a time on a valid/ready byte stream. The final byte is marked as last.

The transmit region is 3072 bytes long, so addresses run from 0x000 to 0xBFF and wrap back to 0x000. When a frame ends, the pointer moves to the address after the last byte. If that address is odd it is raised to the next even one, and the value 0xC00 becomes 0.

Each finished frame gives a one-cycle completion pulse. The pulse lands on one of two network-status flag bits, and the two bits take turns from one frame to the next. The same cycle also sets the interrupt-status bit for transmit completion. The two transmit error status bytes always read zero.

Top module: `tx_ring_engine`

## Requirements
- R1: After a synchronous reset the pointer is 0, busy is 0, no byte is valid, and no status or interrupt pulse is driven. The first frame completes on flag 0.
- R2: busy (read-back of control bit 0) is 1 from the cycle after the start strobe until the completion pulse. It clears by itself in the cycle after that pulse.
- R3: The number of bytes sent equals the length register captured at the start, capped at 3072.
- R4: Byte k of a frame is the SRAM byte at (pointer + k), with the address stepping from 0xBFF to 0x000.
- R5: After completion the pointer is the address that follows the last byte, raised to even if it is odd, and 0 in place of 0xC00. A frame of 3072 bytes leaves the pointer unchanged.
- R6: The completion pulse sets flag_set[0] (network status bit 2) when the packet index is 0, and flag_set[1] (bit 3) when it is 1. The index starts at 0 and toggles after every frame.
- R7: Each completed frame drives irq_set (interrupt status bit 1) high for exactly one cycle, in the same cycle as the flag pulse.
- R8: tx_err is always 0 (both transmit status bytes read zero).
- R9: While valid is high and ready is low, data and last hold steady. last is high on the final byte only.
- R10: A zero-length request sends no byte but still completes, with a flag pulse, an interrupt pulse, and a toggle of the index.
- R11: A start strobe that arrives while busy is high is ignored. The current frame keeps its byte count, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe (control bit 0 written as 1) |
| frame_len_i | input | 16 | Length register |
| busy_o | output | 1 | Read-back of control bit 0 |
| mem_rd_o | output | 1 | SRAM read enable, data one cycle later |
| mem_addr_o | output | 12 | SRAM byte address |
| mem_rdata_i | input | 8 | SRAM read data |
| tx_data_o | output | 8 | Stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_last_o | output | 1 | Final byte of frame |
| tx_ready_i | input | 1 | Downstream ready |
| rd_ptr_o | output | 12 | Transmit read pointer |
| flag_set_o | output | 2 | Set pulses for status bits 2 and 3 |
| irq_set_o | output | 1 | Set pulse for interrupt status bit 1 |
| tx_err_o | output | 16 | Both transmit status bytes, always 0 |

## Verification
The hardest states to reach from the ports are frames that cross the 0xBFF boundary, and a frame that ends on 0xBFF so that rounding produces 0xC00. The pointer can only move by sending whole frames. The stimulus therefore first sends a long frame to place the pointer near the top of the region, then sends a frame that wraps. A second pair first brings the pointer to 0xBF8 and then sends a 7-byte frame whose end rounds to zero. A throttled ready pattern and a second start strobe sent in the middle of a frame check the hold behaviour and the ignore rule.

// File: rtl/txeng_pkg.sv
package txeng_pkg;

    localparam int REGION_BYTES = 3072;
    localparam int FRAME_CAP    = 3072;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_SEND,
        ST_DONE
    } tx_state_e;

    // next byte address inside the circular region
    function automatic int wrap_step(int a, int region);
        return (a == region - 1) ? 0 : a + 1;
    endfunction

    // raise to even, fold the region end back to zero
    function automatic int even_align(int a, int region);
        int r;
        r = a + (a & 1);
        return (r == region) ? 0 : r;
    endfunction

    function automatic int cap_len(int len, int cap);
        return (len > cap) ? cap : len;
    endfunction

endpackage

// File: rtl/tx_addr_gen.sv
module tx_addr_gen #(
    parameter int ADDR_W = 12,
    parameter int REGION = txeng_pkg::REGION_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              commit,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] rd_ptr
);
    logic [ADDR_W-1:0] ptr_q, cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            cur_q <= '0;
        end else begin
            if (load)
                cur_q <= ptr_q;
            else if (step)
                cur_q <= ADDR_W'(txeng_pkg::wrap_step(int'(cur_q), REGION));
            if (commit)
                ptr_q <= ADDR_W'(txeng_pkg::even_align(int'(cur_q), REGION));
        end
    end

    assign cur_addr = cur_q;
    assign rd_ptr   = ptr_q;

    assert_range_R4: assert property (@(posedge clk) disable iff (rst)
        step |=> (int'(cur_q) < REGION));
    assert_even_R5: assert property (@(posedge clk) disable iff (rst)
        commit |=> (!ptr_q[0] && int'(ptr_q) < REGION));
endmodule

// File: rtl/tx_seq.sv
module tx_seq #(
    parameter int LEN_W   = 16,
    parameter int DATA_W  = 8,
    parameter int MAX_LEN = txeng_pkg::FRAME_CAP,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [DATA_W-1:0] rdata,
    input  logic              ready,
    output logic              load,
    output logic              step,
    output logic              mem_rd,
    output logic              done,
    output logic              busy,
    output logic              valid,
    output logic              last,
    output logic [DATA_W-1:0] data
);
    import txeng_pkg::*;

    tx_state_e         st_q, st_d;
    logic [CNT_W-1:0]  rem_q;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  capped;

    assign capped = CNT_W'(cap_len(int'(frame_len), MAX_LEN));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = (capped == '0) ? ST_DONE : ST_READ;
            ST_READ: st_d = ST_WAIT;
            ST_WAIT: st_d = ST_SEND;
            ST_SEND: if (ready) st_d = (rem_q == CNT_W'(1)) ? ST_DONE : ST_READ;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            rem_q  <= '0;
            data_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start)
                rem_q <= capped;
            else if (st_q == ST_SEND && ready)
                rem_q <= rem_q - CNT_W'(1);
            if (st_q == ST_WAIT)
                data_q <= rdata;
        end
    end

    assign load   = (st_q == ST_IDLE) && start;
    assign mem_rd = (st_q == ST_READ);
    assign step   = (st_q == ST_READ);
    assign done   = (st_q == ST_DONE);
    assign busy   = (st_q != ST_IDLE);
    assign valid  = (st_q == ST_SEND);
    assign last   = valid && (rem_q == CNT_W'(1));
    assign data   = data_q;

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(data) && $stable(last)));
    assert_selfclear_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    assert_cap_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (int'(rem_q) <= MAX_LEN));
    assert_ignore_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

// File: rtl/tx_status.sv
module tx_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       done,
    output logic [1:0] flag_set,
    output logic       irq_set
);
    logic idx_q;

    always_ff @(posedge clk) begin
        if (rst)       idx_q <= 1'b0;
        else if (done) idx_q <= ~idx_q;
    end

    assign flag_set = done ? (idx_q ? 2'b10 : 2'b01) : 2'b00;
    assign irq_set  = done;

    assert_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flag_set));
    assert_alternate_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> (idx_q != $past(idx_q)));
    assert_pair_R7: assert property (@(posedge clk) disable iff (rst)
        irq_set |-> ($countones(flag_set) == 1));
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine #(
    parameter int ADDR_W  = 12,
    parameter int REGION  = txeng_pkg::REGION_BYTES,
    parameter int LEN_W   = 16,
    parameter int DATA_W  = 8,
    parameter int MAX_LEN = txeng_pkg::FRAME_CAP,
    parameter int ERR_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  frame_len_i,
    output logic              busy_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              tx_valid_o,
    output logic              tx_last_o,
    input  logic              tx_ready_i,
    output logic [ADDR_W-1:0] rd_ptr_o,
    output logic [1:0]        flag_set_o,
    output logic              irq_set_o,
    output logic [ERR_W-1:0]  tx_err_o
);
    logic load, step, done;

    tx_seq #(.LEN_W(LEN_W), .DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) u_seq (
        .clk(clk), .rst(rst), .start(start_i), .frame_len(frame_len_i),
        .rdata(mem_rdata_i), .ready(tx_ready_i), .load(load), .step(step),
        .mem_rd(mem_rd_o), .done(done), .busy(busy_o), .valid(tx_valid_o),
        .last(tx_last_o), .data(tx_data_o)
    );

    tx_addr_gen #(.ADDR_W(ADDR_W), .REGION(REGION)) u_addr (
        .clk(clk), .rst(rst), .load(load), .step(step), .commit(done),
        .cur_addr(mem_addr_o), .rd_ptr(rd_ptr_o)
    );

    tx_status u_stat (
        .clk(clk), .rst(rst), .done(done),
        .flag_set(flag_set_o), .irq_set(irq_set_o)
    );

    assign tx_err_o = '0;  // no error is ever reported (R8)

    assert_readrange_R4: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> (int'(mem_addr_o) < REGION));
endmodule

// File: tb/sim_tx_ring_engine.sv
module sim_tx_ring_engine;
    localparam int CLK_PERIOD = 10;
    localparam int REGION = 3072;

    logic clk = 0, rst = 1, start = 0, ready = 1, throttle = 0;
    logic [15:0] len = 0;
    logic        busy, mem_rd, valid, last, irq;
    logic [11:0] maddr, ptr;
    logic [7:0]  rdata = 0, data;
    logic [1:0]  flags;
    logic [15:0] err;

    int total = 0, bad = 0, cyc = 0;
    int mptr = 0, midx = 0;
    int mon_addr = 0, mon_n = 0, got = 0;
    int data_err = 0, last_err = 0, stab_err = 0, irq_cnt = 0;
    logic [1:0] last_flags = 0;
    logic prev_stall = 0;
    logic [7:0] prev_data = 0;
    logic prev_last = 0;

    // {throttle, length}
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 16'd5}, {1'b1, 16'd6}, {1'b0, 16'd1},
        {1'b1, 16'd64}, {1'b0, 16'd0}, {1'b1, 16'd3}
    };

    tx_ring_engine u0 (
        .clk(clk), .rst(rst), .start_i(start), .frame_len_i(len),
        .busy_o(busy), .mem_rd_o(mem_rd), .mem_addr_o(maddr),
        .mem_rdata_i(rdata), .tx_data_o(data), .tx_valid_o(valid),
        .tx_last_o(last), .tx_ready_i(ready), .rd_ptr_o(ptr),
        .flag_set_o(flags), .irq_set_o(irq), .tx_err_o(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37) ^ (a >> 4));
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd) rdata <= pat(int'(maddr));
        #1 ready = throttle ? ((cyc % 3) != 1) : 1'b1;
    end

    always @(negedge clk) begin
        if (valid) begin
            if (prev_stall && (data != prev_data || last != prev_last)) stab_err++;
            if (ready) begin
                if (data != pat(mon_addr)) data_err++;
                if (last != (got == mon_n - 1)) last_err++;
                got++;
                mon_addr = (mon_addr == REGION - 1) ? 0 : mon_addr + 1;
            end
            prev_stall = !ready;
            prev_data = data;
            prev_last = last;
        end else begin
            if (prev_stall) stab_err++;
            prev_stall = 0;
        end
        if (irq) begin
            irq_cnt++;
            last_flags = flags;
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic run_frame(int n, logic thr, logic mid_req);
        int exp_n, irq0, fin, busy_seen;
        exp_n = (n > 3072) ? 3072 : n;
        throttle = thr;
        mon_addr = mptr; mon_n = exp_n; got = 0;
        data_err = 0; last_err = 0; stab_err = 0;
        irq0 = irq_cnt;
        @(negedge clk); len = 16'(n); start = 1;
        @(negedge clk); start = 0;
        busy_seen = busy;
        while (!irq) begin
            @(negedge clk);
            if (mid_req && got == 3) begin
                len = 16'd7; start = 1;
                @(negedge clk); start = 0;
            end
        end
        @(negedge clk);
        chk("R2 busy during frame", busy_seen, 1);
        chk("R2 busy self-clear", busy, 0);
        chk("R3 byte count", got, exp_n);
        chk("R4 data/wrap mismatches", data_err, 0);
        chk("R9 last marker errors", last_err, 0);
        chk("R9 hold errors", stab_err, 0);
        chk("R7 one irq per frame", irq_cnt - irq0, 1);
        chk("R6 flag for index", int'(last_flags), midx ? 2 : 1);
        fin = (mptr + exp_n) % REGION;
        fin = fin + (fin & 1);
        if (fin == REGION) fin = 0;
        mptr = fin;
        midx = 1 - midx;
        chk("R5 pointer after frame", int'(ptr), mptr);
        chk("R8 error status zero", int'(err), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int i0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 pointer reset", int'(ptr), 0);
        chk("R1 busy reset", busy, 0);
        chk("R1 valid reset", valid, 0);
        chk("R1 no pulses", int'({flags, irq}), 0);
        chk("R8 error status reset", int'(err), 0);

        foreach (VEC[k]) run_frame(int'(VEC[k][15:0]), VEC[k][16], 1'b0);

        // R10: zero length still completes, twice to see both flags
        run_frame(0, 1'b0, 1'b0);
        chk("R10 no byte sent", got, 0);
        run_frame(0, 1'b1, 1'b0);
        chk("R10 no byte sent on second", got, 0);

        // R11: start strobe mid-frame ignored
        run_frame(20, 1'b1, 1'b1);
        i0 = irq_cnt;
        repeat (12) @(negedge clk);
        chk("R11 no second frame irq", irq_cnt - i0, 0);
        chk("R11 stays idle", busy, 0);

        // R4/R5: long frame then one crossing 0xBFF
        run_frame(3000 - mptr, 1'b0, 1'b0);
        chk("R5 pointer near top", int'(ptr), 3000);
        run_frame(100, 1'b1, 1'b0);
        chk("R4 wrapped pointer", int'(ptr), 28);

        // R3: oversize length capped, pointer returns to itself
        run_frame(5000, 1'b0, 1'b0);
        chk("R3 cap keeps pointer", int'(ptr), 28);

        // R5: end at 0xBFF rounds to 0xC00 which becomes 0
        run_frame(16'hBF8 - 28, 1'b0, 1'b0);
        chk("R5 pointer at 0xBF8", int'(ptr), 16'hBF8);
        run_frame(7, 1'b1, 1'b0);
        chk("R5 fold to zero", int'(ptr), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule